// File: doc/BRIEF.md
# System Register Write Lockdown

This block sits between an instruction decoder and four memory-system control registers: the vector base, the translation control, the upper translation table base and the system control register. It holds those registers together with a 64-bit lock register. Each register write the decoder issues either commits in full, commits only its writable bits, is silently dropped, or is refused with an undefined-instruction pulse.

Boot code writes the lock register early, typically with the vector base, translation control and translation base lock bits plus the master bit (value 0x8000000000000015). After that, the three locked registers can no longer be written. Any attempt traps as an undefined instruction. Writes to the system control register never trap. Once the master bit is set, its MMU-enable bit keeps its value, while pointer-authentication enables and all other bits stay writable. From then on the lock register accepts writes without effect, so nothing can unlock it before the next reset.

Top module: `sysreg_wr_lockdown`

## Requirements
- R1: After reset, all five registers read zero and `undef_o` is low.
- R2: Register IDs are 0 = vector base, 1 = translation control, 2 = translation base, 3 = system control and 4 = lock. A write to an unlocked register with `wr_valid_i` high appears on that register's output at the next rising clock edge.
- R3: While lock bit 0 is set, a write to ID 0 leaves the vector base unchanged and traps.
- R4: While lock bit 2 is set, a write to ID 1 leaves the translation control unchanged and traps.
- R5: While lock bit 4 is set, a write to ID 2 leaves the translation base unchanged and traps.
- R6: A trap raises `undef_o` for exactly one cycle after the edge that took the write, with `undef_id_o` equal to the offending ID. No register changes on that edge.
- R7: A write to ID 3 never traps. While bit 63 of the lock register is clear, all 64 bits of the system control register are written.
- R8: While bit 63 is set, a write to ID 3 leaves bit 0 at its old value and stores every other bit, including bits 31, 27 and 13, from the write data.
- R9: While bit 63 is clear, the lock register takes any written value, so lock bits can be both set and cleared.
- R10: While bit 63 is set, a write to ID 4 raises no trap and leaves the lock register unchanged. Bit 63 stays set until reset.
- R11: Writes to IDs 5 to 7 change no register and raise no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid_i | input | 1 | Register-write request valid |
| wr_id_i | input | 3 | Target register ID |
| wr_data_i | input | 64 | Write data |
| vec_base_o | output | 64 | Vector base register value |
| xlat_ctl_o | output | 64 | Translation control register value |
| xlat_base_o | output | 64 | Translation table base register value |
| sys_ctl_o | output | 64 | System control register value |
| lock_o | output | 64 | Lock register value |
| undef_o | output | 1 | One-cycle undefined-instruction pulse |
| undef_id_o | output | 3 | ID of the trapped write |

## Verification
The properties assume that `wr_id_i` and `wr_data_i` are known whenever `wr_valid_i` is high. They also assume that a request lasts one cycle and that each cycle is a separate write. The bench drives one request at a time on the falling edge and holds valid low for an idle cycle after each request, so that a new write never overlaps the end of a trap pulse. It sweeps every combination of the three lock bits against every ID before arming the master bit. After that it repeats the sweep, including unlock attempts.

// File: rtl/wrlock_pkg.sv
package wrlock_pkg;
    localparam int unsigned REG_W = 64;
    localparam int unsigned ID_W  = 3;

    typedef enum logic [ID_W-1:0] {
        RID_VEC   = 3'd0,
        RID_XCTL  = 3'd1,
        RID_XBASE = 3'd2,
        RID_SCTL  = 3'd3,
        RID_LOCK  = 3'd4
    } reg_id_e;

    typedef enum logic [1:0] {
        ACT_DROP   = 2'd0,
        ACT_FULL   = 2'd1,
        ACT_MASKED = 2'd2,
        ACT_TRAP   = 2'd3
    } wr_act_e;

    typedef struct packed {
        logic [REG_W-1:0] vec;
        logic [REG_W-1:0] xctl;
        logic [REG_W-1:0] xbase;
        logic [REG_W-1:0] sctl;
        logic [REG_W-1:0] lock;
        logic             undef;
        logic [ID_W-1:0]  undef_id;
    } lk_state_t;
endpackage

// File: rtl/wrlock_policy.sv
module wrlock_policy
    import wrlock_pkg::*;
#(
    parameter int unsigned VEC_BIT    = 0,
    parameter int unsigned XCTL_BIT   = 2,
    parameter int unsigned XBASE_BIT  = 4,
    parameter int unsigned MASTER_BIT = 63
) (
    input  logic [ID_W-1:0]  id_i,
    input  logic [REG_W-1:0] lock_i,
    output wr_act_e          act_o
);
    // Per-register lock bit lookup; registers without a lock bit never trap.
    function automatic wr_act_e guarded(input logic locked);
        return locked ? ACT_TRAP : ACT_FULL;
    endfunction

    always_comb begin
        act_o = ACT_DROP;
        case (id_i)
            RID_VEC:   act_o = guarded(lock_i[VEC_BIT]);
            RID_XCTL:  act_o = guarded(lock_i[XCTL_BIT]);
            RID_XBASE: act_o = guarded(lock_i[XBASE_BIT]);
            RID_SCTL:  act_o = lock_i[MASTER_BIT] ? ACT_MASKED : ACT_FULL;
            RID_LOCK:  act_o = lock_i[MASTER_BIT] ? ACT_DROP : ACT_FULL;
            default:   act_o = ACT_DROP;
        endcase
    end
endmodule

// File: rtl/wrlock_merge.sv
module wrlock_merge
    import wrlock_pkg::*;
#(
    parameter logic [REG_W-1:0] KEEP_MASK = 64'h1
) (
    input  logic             keep_en_i,
    input  logic [REG_W-1:0] old_i,
    input  logic [REG_W-1:0] new_i,
    output logic [REG_W-1:0] out_o
);
    // Frozen bit positions retain the old value only while keep_en_i is set.
    for (genvar b = 0; b < REG_W; b++) begin : g_bit
        if (KEEP_MASK[b]) begin : g_keep
            assign out_o[b] = keep_en_i ? old_i[b] : new_i[b];
        end else begin : g_pass
            assign out_o[b] = new_i[b];
        end
    end
endmodule

// File: rtl/sysreg_wr_lockdown.sv
module sysreg_wr_lockdown
    import wrlock_pkg::*;
#(
    parameter int unsigned      VEC_BIT    = 0,
    parameter int unsigned      XCTL_BIT   = 2,
    parameter int unsigned      XBASE_BIT  = 4,
    parameter int unsigned      MASTER_BIT = 63,
    parameter logic [REG_W-1:0] SCTL_FROZEN = 64'h1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_valid_i,
    input  logic [ID_W-1:0]  wr_id_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] vec_base_o,
    output logic [REG_W-1:0] xlat_ctl_o,
    output logic [REG_W-1:0] xlat_base_o,
    output logic [REG_W-1:0] sys_ctl_o,
    output logic [REG_W-1:0] lock_o,
    output logic             undef_o,
    output logic [ID_W-1:0]  undef_id_o
);
    lk_state_t        st_d, st_q;
    wr_act_e          act;
    logic [REG_W-1:0] sctl_merged;

    wrlock_policy #(
        .VEC_BIT   (VEC_BIT),
        .XCTL_BIT  (XCTL_BIT),
        .XBASE_BIT (XBASE_BIT),
        .MASTER_BIT(MASTER_BIT)
    ) u_policy (
        .id_i  (wr_id_i),
        .lock_i(st_q.lock),
        .act_o (act)
    );

    wrlock_merge #(
        .KEEP_MASK(SCTL_FROZEN)
    ) u_merge (
        .keep_en_i(act == ACT_MASKED),
        .old_i    (st_q.sctl),
        .new_i    (wr_data_i),
        .out_o    (sctl_merged)
    );

    always_comb begin
        st_d          = st_q;
        st_d.undef    = 1'b0;
        st_d.undef_id = '0;
        if (wr_valid_i) begin
            if (act == ACT_TRAP) begin
                st_d.undef    = 1'b1;
                st_d.undef_id = wr_id_i;
            end else if (act != ACT_DROP) begin
                case (wr_id_i)
                    RID_VEC:   st_d.vec   = wr_data_i;
                    RID_XCTL:  st_d.xctl  = wr_data_i;
                    RID_XBASE: st_d.xbase = wr_data_i;
                    RID_SCTL:  st_d.sctl  = sctl_merged;
                    RID_LOCK:  st_d.lock  = wr_data_i;
                    default:   ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign vec_base_o  = st_q.vec;
    assign xlat_ctl_o  = st_q.xctl;
    assign xlat_base_o = st_q.xbase;
    assign sys_ctl_o   = st_q.sctl;
    assign lock_o      = st_q.lock;
    assign undef_o     = st_q.undef;
    assign undef_id_o  = st_q.undef_id;
endmodule

// File: rtl/wrlock_checker.sv
module wrlock_checker
    import wrlock_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             wr_valid_i,
    input logic [ID_W-1:0]  wr_id_i,
    input logic [REG_W-1:0] wr_data_i,
    input logic [REG_W-1:0] vec_base_o,
    input logic [REG_W-1:0] xlat_ctl_o,
    input logic [REG_W-1:0] xlat_base_o,
    input logic [REG_W-1:0] sys_ctl_o,
    input logic [REG_W-1:0] lock_o,
    input logic             undef_o,
    input logic [ID_W-1:0]  undef_id_o
);
    assert_unlocked_commit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i == 3'd0 && !lock_o[0]) |=> (vec_base_o == $past(wr_data_i)));

    assert_vec_trap_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i == 3'd0 && lock_o[0]) |=> ($stable(vec_base_o) && undef_o));

    assert_xctl_trap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i == 3'd1 && lock_o[2]) |=> ($stable(xlat_ctl_o) && undef_o));

    assert_xbase_trap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i == 3'd2 && lock_o[4]) |=> ($stable(xlat_base_o) && undef_o));

    // R6: a trap pulse comes only from a write in the cycle before and freezes every register
    assert_trap_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        undef_o |-> ($past(wr_valid_i) && undef_id_o == $past(wr_id_i) && $stable(vec_base_o)
                     && $stable(xlat_ctl_o) && $stable(xlat_base_o) && $stable(sys_ctl_o)
                     && $stable(lock_o)));

    assert_sctl_no_trap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i == 3'd3) |=> !undef_o);

    assert_sctl_partial_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i == 3'd3 && lock_o[63]) |=>
            (sys_ctl_o[0] == $past(sys_ctl_o[0]) && sys_ctl_o[31] == $past(wr_data_i[31])
             && sys_ctl_o[27] == $past(wr_data_i[27]) && sys_ctl_o[13] == $past(wr_data_i[13])));

    assert_lock_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i == 3'd4 && lock_o[63]) |=> ($stable(lock_o) && !undef_o));

    assert_master_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        lock_o[63] |=> lock_o[63]);

    assert_unknown_id_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid_i && wr_id_i > 3'd4) |=> !undef_o);
endmodule

bind sysreg_wr_lockdown wrlock_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_valid_i (wr_valid_i),
    .wr_id_i    (wr_id_i),
    .wr_data_i  (wr_data_i),
    .vec_base_o (vec_base_o),
    .xlat_ctl_o (xlat_ctl_o),
    .xlat_base_o(xlat_base_o),
    .sys_ctl_o  (sys_ctl_o),
    .lock_o     (lock_o),
    .undef_o    (undef_o),
    .undef_id_o (undef_id_o)
);

// File: tb/tb_sysreg_wr_lockdown.sv
module tb_sysreg_wr_lockdown;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_valid_i = 1'b0;
    logic [2:0]  wr_id_i = '0;
    logic [63:0] wr_data_i = '0;
    logic [63:0] vec_base_o, xlat_ctl_o, xlat_base_o, sys_ctl_o, lock_o;
    logic        undef_o;
    logic [2:0]  undef_id_o;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 0;

    // expected model
    logic [63:0] m_reg [5];
    logic        m_undef;
    logic [2:0]  m_uid;

    always #2.5 clk = ~clk;

    sysreg_wr_lockdown dut (
        .clk(clk), .rst_n(rst_n), .wr_valid_i(wr_valid_i), .wr_id_i(wr_id_i),
        .wr_data_i(wr_data_i), .vec_base_o(vec_base_o), .xlat_ctl_o(xlat_ctl_o),
        .xlat_base_o(xlat_base_o), .sys_ctl_o(sys_ctl_o), .lock_o(lock_o),
        .undef_o(undef_o), .undef_id_o(undef_id_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk(req, "vec_base",  vec_base_o,  m_reg[0]);
        chk(req, "xlat_ctl",  xlat_ctl_o,  m_reg[1]);
        chk(req, "xlat_base", xlat_base_o, m_reg[2]);
        chk(req, "sys_ctl",   sys_ctl_o,   m_reg[3]);
        chk(req, "lock",      lock_o,      m_reg[4]);
        chk(req, "undef",     {63'd0, undef_o}, {63'd0, m_undef});
        if (m_undef) chk(req, "undef_id", {61'd0, undef_id_o}, {61'd0, m_uid});
    endtask

    // Apply one write, predict from the requirements, check after the edge and after an idle cycle.
    task automatic do_write(input logic [2:0] id, input logic [63:0] data);
        string req;
        logic  trap;
        logic [63:0] lk;
        lk   = m_reg[4];
        trap = (id == 3'd0 && lk[0]) || (id == 3'd1 && lk[2]) || (id == 3'd2 && lk[4]);
        if (trap) begin
            req = (id == 3'd0) ? "R3" : (id == 3'd1) ? "R4" : "R5";
        end else if (id <= 3'd2) begin
            req = "R2";
            m_reg[id] = data;
        end else if (id == 3'd3) begin
            if (lk[63]) begin
                req = "R8";
                m_reg[3] = {data[63:1], m_reg[3][0]};
            end else begin
                req = "R7";
                m_reg[3] = data;
            end
        end else if (id == 3'd4) begin
            if (lk[63]) req = "R10";
            else begin
                req = "R9";
                m_reg[4] = data;
            end
        end else begin
            req = "R11";
        end
        m_undef = trap;
        m_uid   = id;
        @(negedge clk);
        wr_valid_i = 1'b1;
        wr_id_i    = id;
        wr_data_i  = data;
        @(negedge clk);
        wr_valid_i = 1'b0;
        wr_data_i  = ~data;
        check_all(req);
        @(negedge clk);
        m_undef = 1'b0;
        check_all(trap ? "R6" : req);
    endtask

    function automatic logic [63:0] pat(input int k);
        return {32'hA5C3_0000 ^ 32'(k * 32'h9E37), 32'h1234_5678 + 32'(k * 32'h0101_0101)} ^ 64'h8000_0000_0000_0001;
    endfunction

    initial begin : watchdog
        for (int c = 0; c < 100000; c++) begin
            @(posedge clk);
            if (done) disable watchdog;
        end
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5; i++) m_reg[i] = '0;
        m_undef = 1'b0;
        m_uid   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // Before master: every lock-bit combination against every ID, then unlock (R9).
        for (int combo = 0; combo < 8; combo++) begin
            do_write(3'd4, {59'd0, combo[2], 1'b0, combo[1], 1'b0, combo[0]});
            for (int id = 0; id < 8; id++) begin
                if (id != 4) do_write(3'(id), pat(combo * 8 + id));
            end
            do_write(3'd4, 64'd0);
        end
        do_write(3'd3, 64'h0000_0000_0000_0001);   // MMU enable before arming (R7)

        // Arm the lock with the boot value.
        do_write(3'd4, 64'h8000_0000_0000_0015);
        for (int k = 0; k < 4; k++) begin
            for (int id = 0; id < 8; id++) do_write(3'(id), pat(100 + k * 8 + id));
        end
        // Partial system control writes: try to clear MMU enable, toggle PAC bits (R8).
        do_write(3'd3, 64'h0000_0000_8800_2000);
        do_write(3'd3, 64'h0000_0000_0000_0000);
        do_write(3'd3, 64'hFFFF_FFFF_FFFF_FFFE);
        // Unlock attempts (R10).
        do_write(3'd4, 64'd0);
        do_write(3'd4, 64'hFFFF_FFFF_FFFF_FFFF);
        do_write(3'd4, 64'h0000_0000_0000_0015);
        do_write(3'd0, 64'hDEAD_BEEF_0000_0000);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule